// File: doc/BRIEF.md
# Four-Port Shared-Write Register-File RAM

This block is a small storage element made of four identical arrays, each 32 words deep and 2 bits wide by default. The arrays are written together: one clock, one write enable and one write address serve all four, while each array takes its own data word. Port D's address selects the write location and also the location that port D reads. Ports A, B and C are read-only, and each has a read address of its own.

Reads are purely combinational. An output follows its address with no clock, so a location being written shows its old contents until the active edge and its new contents straight after it. The active clock edge is set by a parameter. The starting contents of each array are set by a packed parameter image. The memory has no runtime reset, so the arrays hold the image from time zero until they are written.

Top module: `lut_quad_ram`

## Requirements
- R1: On the active clock edge with `wr_en` high, every array k stores `din_k` at the location `addr_d`, all four in that same edge.
- R2: With `wr_en` low, a clock edge changes no location of any array, whatever `din_a`..`din_d` and `addr_d` hold.
- R3: Every read output is combinational: `dout_k` shows the contents of the addressed location of array k within the same cycle, with no clock edge needed.
- R4: `raddr_a`, `raddr_b` and `raddr_c` are independent, so ports A, B and C can read three different locations in the same cycle.
- R5: Port D always reads array D at `addr_d`, the same address that is used for writing.
- R6: While a write to a location is pending, a read of that location returns the old word up to the active edge and the new word right after it.
- R7: Before any write, location i of an array holds bits [W*i+W-1 : W*i] of that array's image parameter (`INIT_A`..`INIT_D`).
- R8: With `CLK_FALL` = 0 writes take place on the rising clock edge. With `CLK_FALL` = 1 they take place on the falling edge, and a rising edge leaves the contents unchanged.
- R9: A write changes only the location at `addr_d`. All other locations of every array keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; the active edge is set by `CLK_FALL` |
| wr_en | input | 1 | Active-high write enable, shared by all arrays |
| addr_d | input | AW | Shared write address, also port D read address |
| raddr_a | input | AW | Port A read address |
| raddr_b | input | AW | Port B read address |
| raddr_c | input | AW | Port C read address |
| din_a | input | WIDTH | Write data for array A |
| din_b | input | WIDTH | Write data for array B |
| din_c | input | WIDTH | Write data for array C |
| din_d | input | WIDTH | Write data for array D |
| dout_a | output | WIDTH | Port A read data |
| dout_b | output | WIDTH | Port B read data |
| dout_c | output | WIDTH | Port C read data |
| dout_d | output | WIDTH | Port D read data |

## Verification
The bench builds two copies at the default 32 x 2 size: one with `CLK_FALL` = 0 and one with `CLK_FALL` = 1. Each copy is loaded with an image in which location i of array k holds (3i + k) mod 4. At this size every location of every array can be swept for its initial value, written once and read back. Both copies run on the same stimulus, so one write shows the new word on the falling-edge copy after the falling edge while the rising-edge copy still shows the old word. A pseudo-random phase then mixes writes with three unrelated read addresses and checks all eight outputs against a reference array in every cycle.

// File: rtl/lqr_pkg.sv
package lqr_pkg;

    // Number of read ports; the last one shares its address with the write path.
    localparam int NPORT = 4;

    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_C = 2'd2,
        PORT_D = 2'd3
    } port_id_e;

    localparam port_id_e WR_PORT = PORT_D;

endpackage

// File: rtl/lqr_wdec.sv
// Write address decoder: one-hot row strobe for the shared write path.
module lqr_wdec #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    output logic [DEPTH-1:0] row_we
);

    always_comb begin
        row_we = '0;
        for (int r = 0; r < DEPTH; r++) begin
            if (we && (waddr == AW'(r))) begin
                row_we[r] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lqr_bank.sv
// One storage array: synchronous write through row strobes, combinational read.
module lqr_bank #(
    parameter int               DEPTH    = 32,
    parameter int               WIDTH    = 2,
    parameter int               AW       = $clog2(DEPTH),
    parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
    parameter bit               CLK_FALL = 1'b0
) (
    input  logic             clk,
    input  logic [DEPTH-1:0] row_we,
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] cells;
    } bank_t;

    bank_t st_d;
    bank_t st_q;

    // Power-up image; there is no runtime reset.
    initial begin
        st_q.cells = INIT;
    end

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < DEPTH; r++) begin
            if (row_we[r]) begin
                st_d.cells[r] = din;
            end
        end
    end

    generate
        if (CLK_FALL) begin : g_fall
            always_ff @(negedge clk) begin
                st_q <= st_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign dout = st_q.cells[raddr];

endmodule

// File: rtl/lut_quad_ram.sv
// Four arrays with one shared write path and four asynchronous read ports.
module lut_quad_ram #(
    parameter int DEPTH    = 32,
    parameter int WIDTH    = 2,
    parameter int AW       = $clog2(DEPTH),
    parameter bit CLK_FALL = 1'b0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_A = '0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_B = '0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_C = '0,
    parameter logic [DEPTH*WIDTH-1:0] INIT_D = '0
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr_d,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    input  logic [AW-1:0]    raddr_c,
    input  logic [WIDTH-1:0] din_a,
    input  logic [WIDTH-1:0] din_b,
    input  logic [WIDTH-1:0] din_c,
    input  logic [WIDTH-1:0] din_d,
    output logic [WIDTH-1:0] dout_a,
    output logic [WIDTH-1:0] dout_b,
    output logic [WIDTH-1:0] dout_c,
    output logic [WIDTH-1:0] dout_d
);

    import lqr_pkg::*;

    localparam int IMG_W = DEPTH * WIDTH;

    logic [DEPTH-1:0] row_we;
    logic [AW-1:0]    rd_addr [NPORT];
    logic [WIDTH-1:0] wr_data [NPORT];
    logic [WIDTH-1:0] rd_data [NPORT];

    assign rd_addr[PORT_A]  = raddr_a;
    assign rd_addr[PORT_B]  = raddr_b;
    assign rd_addr[PORT_C]  = raddr_c;
    assign rd_addr[WR_PORT] = addr_d;

    assign wr_data[PORT_A] = din_a;
    assign wr_data[PORT_B] = din_b;
    assign wr_data[PORT_C] = din_c;
    assign wr_data[PORT_D] = din_d;

    lqr_wdec #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_wdec (
        .we     (wr_en),
        .waddr  (addr_d),
        .row_we (row_we)
    );

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_bank
            localparam logic [IMG_W-1:0] IMG =
                (g == 0) ? INIT_A :
                (g == 1) ? INIT_B :
                (g == 2) ? INIT_C : INIT_D;

            lqr_bank #(
                .DEPTH    (DEPTH),
                .WIDTH    (WIDTH),
                .AW       (AW),
                .INIT     (IMG),
                .CLK_FALL (CLK_FALL)
            ) u_bank (
                .clk    (clk),
                .row_we (row_we),
                .din    (wr_data[g]),
                .raddr  (rd_addr[g]),
                .dout   (rd_data[g])
            );
        end
    endgenerate

    assign dout_a = rd_data[PORT_A];
    assign dout_b = rd_data[PORT_B];
    assign dout_c = rd_data[PORT_C];
    assign dout_d = rd_data[PORT_D];

endmodule

// File: rtl/lqr_chk.sv
// Property checker, bound onto every lut_quad_ram instance.
module lqr_chk #(
    parameter int AW       = 5,
    parameter int WIDTH    = 2,
    parameter bit CLK_FALL = 1'b0
) (
    input logic             clk,
    input logic             wr_en,
    input logic [AW-1:0]    addr_d,
    input logic [AW-1:0]    raddr_a,
    input logic [AW-1:0]    raddr_b,
    input logic [WIDTH-1:0] din_a,
    input logic [WIDTH-1:0] din_d,
    input logic [WIDTH-1:0] dout_a,
    input logic [WIDTH-1:0] dout_b,
    input logic [WIDTH-1:0] dout_d
);

    logic eclk;
    logic armed = 1'b0;

    assign eclk = clk ^ CLK_FALL;

    always_ff @(posedge eclk) begin
        armed <= 1'b1;
    end

    AST_WRITE_VISIBLE_A: assert property (@(posedge eclk) disable iff (!armed)
        (wr_en && (raddr_a == addr_d)) |=>
            ((raddr_a != $past(raddr_a)) || (dout_a == $past(din_a)))); // R1

    AST_PORTD_WRITE_READ: assert property (@(posedge eclk) disable iff (!armed)
        wr_en |=> ((addr_d != $past(addr_d)) || (dout_d == $past(din_d)))); // R5

    AST_NO_WRITE_HOLD: assert property (@(posedge eclk) disable iff (!armed)
        !wr_en |=> ((addr_d != $past(addr_d)) || (dout_d == $past(dout_d)))); // R2

    AST_OTHER_ROW_KEPT: assert property (@(posedge eclk) disable iff (!armed)
        (wr_en && (raddr_b != addr_d)) |=>
            ((raddr_b != $past(raddr_b)) || (dout_b == $past(dout_b)))); // R9

endmodule

bind lut_quad_ram lqr_chk #(
    .AW       (AW),
    .WIDTH    (WIDTH),
    .CLK_FALL (CLK_FALL)
) u_chk (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr_d  (addr_d),
    .raddr_a (raddr_a),
    .raddr_b (raddr_b),
    .din_a   (din_a),
    .din_d   (din_d),
    .dout_a  (dout_a),
    .dout_b  (dout_b),
    .dout_d  (dout_d)
);

// File: tb/lut_quad_ram_tb.sv
`timescale 1ns/100ps
module lut_quad_ram_tb;

    localparam int DEPTH = 32;
    localparam int WIDTH = 2;
    localparam int AW    = 5;

    function automatic logic [DEPTH*WIDTH-1:0] img(input int k);
        logic [DEPTH*WIDTH-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            v[WIDTH*i +: WIDTH] = WIDTH'((i * 3 + k) % 4);
        end
        return v;
    endfunction

    logic             clk = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    ad = '0, ra = '0, rb = '0, rc = '0;
    logic [WIDTH-1:0] da = '0, db = '0, dc = '0, dd = '0;
    logic [WIDTH-1:0] oa, ob, oc, od;
    logic [WIDTH-1:0] fa, fb, fc, fd;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [WIDTH-1:0] mdl [4][DEPTH];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lut_quad_ram #(
        .DEPTH (DEPTH), .WIDTH (WIDTH), .AW (AW), .CLK_FALL (1'b0),
        .INIT_A (img(0)), .INIT_B (img(1)), .INIT_C (img(2)), .INIT_D (img(3))
    ) u_dut (
        .clk (clk), .wr_en (wr_en), .addr_d (ad),
        .raddr_a (ra), .raddr_b (rb), .raddr_c (rc),
        .din_a (da), .din_b (db), .din_c (dc), .din_d (dd),
        .dout_a (oa), .dout_b (ob), .dout_c (oc), .dout_d (od)
    );

    lut_quad_ram #(
        .DEPTH (DEPTH), .WIDTH (WIDTH), .AW (AW), .CLK_FALL (1'b1),
        .INIT_A (img(0)), .INIT_B (img(1)), .INIT_C (img(2)), .INIT_D (img(3))
    ) u_dut_fall (
        .clk (clk), .wr_en (wr_en), .addr_d (ad),
        .raddr_a (ra), .raddr_b (rb), .raddr_c (rc),
        .din_a (da), .din_b (db), .din_c (dc), .din_d (dd),
        .dout_a (fa), .dout_b (fb), .dout_c (fc), .dout_d (fd)
    );

    task automatic chk(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // Both copies against the reference at the current addresses.
    task automatic chk_all(input string tag);
        chk({tag, " A"}, oa, mdl[0][ra]);
        chk({tag, " B"}, ob, mdl[1][rb]);
        chk({tag, " C"}, oc, mdl[2][rc]);
        chk({tag, " D"}, od, mdl[3][ad]);
        chk({tag, " fall A"}, fa, mdl[0][ra]);
        chk({tag, " fall B"}, fb, mdl[1][rb]);
        chk({tag, " fall C"}, fc, mdl[2][rc]);
        chk({tag, " fall D"}, fd, mdl[3][ad]);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    // One write with old/new checks around both active edges (R6, R8).
    task automatic write_cycle(input logic [AW-1:0] a, input logic [WIDTH-1:0] w0,
                               input logic [WIDTH-1:0] w1, input logic [WIDTH-1:0] w2,
                               input logic [WIDTH-1:0] w3);
        @(posedge clk);
        #1;
        ad = a; ra = a; rb = a; rc = a;
        da = w0; db = w1; dc = w2; dd = w3;
        wr_en = 1'b1;
        #0.5;
        chk("R6 old before edge", oa, mdl[0][a]);
        chk("R6 old before edge fall", fd, mdl[3][a]);
        @(negedge clk);
        #0.5;
        chk("R8 fall copy written on falling edge", fa, w0);
        chk("R8 rise copy unchanged on falling edge", oa, mdl[0][a]);
        @(posedge clk);
        #0.5;
        wr_en = 1'b0;
        mdl[0][a] = w0; mdl[1][a] = w1; mdl[2][a] = w2; mdl[3][a] = w3;
        chk("R6 new after edge", oa, w0);
        chk_all("R1 write all four");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < DEPTH; i++)
                mdl[k][i] = WIDTH'((i * 3 + k) % 4);

        // R7, R3, R4, R5: image sweep with three unrelated read addresses
        for (int i = 0; i < DEPTH; i++) begin
            ad = AW'(i); ra = AW'(i); rb = AW'(i + 5); rc = AW'(i + 17);
            #1;
            chk_all("R7 R3 R4 R5 initial image");
        end

        // R1, R6, R8: write every location
        for (int i = 0; i < DEPTH; i++) begin
            write_cycle(AW'(i), WIDTH'(i + 1), WIDTH'(i + 2), WIDTH'(~i), WIDTH'(i >> 1));
        end

        // R9, R4: read back everything with scattered addresses
        for (int i = 0; i < DEPTH; i++) begin
            ad = AW'(i); ra = AW'(31 - i); rb = AW'(i * 7); rc = AW'(i + 3);
            #1;
            chk_all("R9 R4 readback");
        end

        // R2: edges with enable low and fresh data leave contents alone
        @(posedge clk);
        #1;
        ad = 5'd9; ra = 5'd9; rb = 5'd9; rc = 5'd9;
        da = ~mdl[0][9]; db = ~mdl[1][9]; dc = ~mdl[2][9]; dd = ~mdl[3][9];
        wr_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk_all("R2 disabled write ignored");

        // Pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            @(posedge clk);
            #1;
            seed = nxt(seed);
            ad = seed[4:0]; ra = seed[9:5]; rb = seed[14:10]; rc = seed[19:15];
            da = seed[21:20]; db = seed[23:22]; dc = seed[25:24]; dd = seed[27:26];
            wr_en = seed[29];
            #0.5;
            chk_all("R3 R4 random read");
            if (wr_en) begin
                mdl[0][ad] = da; mdl[1][ad] = db; mdl[2][ad] = dc; mdl[3][ad] = dd;
            end
        end
        @(posedge clk);
        #1.5;
        wr_en = 1'b0;
        chk_all("R1 R9 final state");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule